// File: doc/BRIEF.md
# Three-Button Mouse Packet Encoder

This block turns one pointer event into a fixed five-byte packet and hands the bytes, one at a time, to a byte FIFO on a receive path. An event carries two signed 16-bit movement deltas and the state of the left, middle and right buttons. The block builds a status byte with the button states in it, saturates the horizontal delta and the negated vertical delta to one signed byte each, and appends two zero bytes.

The upstream side offers an event with a valid/ready pair. The encoder takes the event only when it has no packet in flight and the FIFO reports at least five free slots. The packet is always complete once it starts. The downstream side drains it through a second valid/ready pair, one byte per handshake.

Top module: `mouse_packet_enc`

## Requirements
- R1: After reset the encoder holds no packet: `outValid` is low and `evtReady` follows the free-slot rule of R7.
- R2: The first byte of a packet is the status byte. It is 0x87 with no buttons pressed. A pressed left button clears bit 2, a pressed middle button clears bit 1 and a pressed right button clears bit 0.
- R3: The second byte is the horizontal delta in two's complement. A value above +127 is sent as 0x7F and a value below -127 is sent as 0x81. The comparison uses the full 16-bit input.
- R4: The third byte is the vertical delta negated and then saturated to -127..+127. It is negated at full width, so -32768 becomes 0x7F.
- R5: The fourth and fifth bytes are always 0x00.
- R6: The bytes leave in the order status, X, Y, zero, zero, and one byte moves per cycle in which `outValid` and `outReady` are both high. While `outReady` is low, `outValid` and `outData` hold their values.
- R7: `evtReady` is high exactly when no packet is in flight and `fifoFree` is 5 or more. An event is taken in a cycle in which `evtValid` and `evtReady` are both high, and the first byte is valid in the following cycle.
- R8: An event offered while a packet is in flight has no effect on the bytes of that packet, and it is not queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Event offered |
| evtReady | output | 1 | Event can be taken this cycle |
| evtDx | input | 16 | Signed horizontal delta |
| evtDy | input | 16 | Signed vertical delta |
| btnLeft | input | 1 | Left button pressed |
| btnMiddle | input | 1 | Middle button pressed |
| btnRight | input | 1 | Right button pressed |
| fifoFree | input | 4 | Free byte slots in the downstream FIFO |
| outValid | output | 1 | Packet byte valid |
| outData | output | 8 | Packet byte |
| outReady | input | 1 | Downstream takes the byte |

## Verification
The case that is hardest to reach from the ports is an event offered while a packet is still draining with long gaps in `outReady`. Only there can a wrong design overwrite the saved deltas in the middle of a packet. The stimulus keeps `evtValid` high through whole packets while it toggles `outReady` at random. It also holds `fifoFree` at 4 and then at 5 to probe the edge of the room rule. The directed deltas cover ±127, ±128 and both 16-bit extremes on each axis. This includes vertical -32768, whose negation does not fit in 16 bits.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int PKT_LEN = 5;
  localparam int IDX_W   = $clog2(PKT_LEN);
  localparam logic [7:0] HDR_IDLE = 8'h87;

  typedef struct packed {
    logic             load;   // capture event into the byte registers
    logic [IDX_W-1:0] sel;    // which packet byte drives outData
  } mpeStrobe_t;
endpackage

// File: rtl/mpe_datapath.sv
module mpe_datapath
  import mpe_pkg::*;
#(
  parameter int DELTA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  mpeStrobe_t         strobe,
  input  logic [DELTA_W-1:0] evtDx,
  input  logic [DELTA_W-1:0] evtDy,
  input  logic               btnLeft,
  input  logic               btnMiddle,
  input  logic               btnRight,
  output logic [7:0]         outData
);
  localparam int EXT_W = DELTA_W + 1;
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'(127);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [EXT_W-1:0] xExt, yNeg;
  logic [7:0] xSat, ySat, hdrNext;
  logic [7:0] hdrQ, xQ, yQ;

  always_comb begin
    xExt = $signed({evtDx[DELTA_W-1], evtDx});
    yNeg = -$signed({evtDy[DELTA_W-1], evtDy});
    if (xExt > POS_LIM)      xSat = POS_LIM[7:0];
    else if (xExt < NEG_LIM) xSat = NEG_LIM[7:0];
    else                     xSat = xExt[7:0];
    if (yNeg > POS_LIM)      ySat = POS_LIM[7:0];
    else if (yNeg < NEG_LIM) ySat = NEG_LIM[7:0];
    else                     ySat = yNeg[7:0];
    hdrNext = HDR_IDLE & ~{5'b00000, btnLeft, btnMiddle, btnRight};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrQ <= HDR_IDLE;
      xQ   <= '0;
      yQ   <= '0;
    end else if (strobe.load) begin
      hdrQ <= hdrNext;
      xQ   <= xSat;
      yQ   <= ySat;
    end
  end

  always_comb begin
    case (strobe.sel)
      IDX_W'(0): outData = hdrQ;
      IDX_W'(1): outData = xQ;
      IDX_W'(2): outData = yQ;
      default:   outData = 8'h00;
    endcase
  end
endmodule

// File: rtl/mpe_control.sv
module mpe_control
  import mpe_pkg::*;
#(
  parameter int FREE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [FREE_W-1:0] fifoFree,
  input  logic              outReady,
  output logic              evtReady,
  output logic              outValid,
  output mpeStrobe_t        strobe
);
  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);

  state_t           stateQ;
  logic [IDX_W-1:0] idxQ;
  logic             take, moved;

  always_comb begin
    evtReady    = (stateQ == ST_IDLE) && (32'(fifoFree) >= PKT_LEN);
    outValid    = (stateQ == ST_SEND);
    take        = evtValid && evtReady;
    moved       = outValid && outReady;
    strobe.load = take;
    strobe.sel  = idxQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
    end else begin
      case (stateQ)
        ST_IDLE: if (take) begin
          stateQ <= ST_SEND;
          idxQ   <= '0;
        end
        ST_SEND: if (moved) begin
          if (idxQ == LAST_IDX) begin
            stateQ <= ST_IDLE;
            idxQ   <= '0;
          end else begin
            idxQ <= idxQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mouse_packet_enc.sv
module mouse_packet_enc
  import mpe_pkg::*;
#(
  parameter int DELTA_W = 16,
  parameter int FREE_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               evtValid,
  output logic               evtReady,
  input  logic [DELTA_W-1:0] evtDx,
  input  logic [DELTA_W-1:0] evtDy,
  input  logic               btnLeft,
  input  logic               btnMiddle,
  input  logic               btnRight,
  input  logic [FREE_W-1:0]  fifoFree,
  output logic               outValid,
  output logic [7:0]         outData,
  input  logic               outReady
);
  mpeStrobe_t strobe;

  mpe_control #(.FREE_W(FREE_W)) ctrl (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .fifoFree(fifoFree),
    .outReady(outReady), .evtReady(evtReady), .outValid(outValid),
    .strobe(strobe)
  );

  mpe_datapath #(.DELTA_W(DELTA_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evtDx(evtDx), .evtDy(evtDy),
    .btnLeft(btnLeft), .btnMiddle(btnMiddle), .btnRight(btnRight),
    .outData(outData)
  );
endmodule

// File: rtl/mpe_checker.sv
module mpe_checker #(
  parameter int FREE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              evtValid,
  input logic              evtReady,
  input logic [FREE_W-1:0] fifoFree,
  input logic              outValid,
  input logic [7:0]        outData,
  input logic              outReady
);
  logic [2:0] seenCnt;

  always_ff @(posedge clk) begin
    if (!rstN) seenCnt <= '0;
    else if (evtValid && evtReady) seenCnt <= '0;
    else if (outValid && outReady) seenCnt <= (seenCnt == 3'd4) ? 3'd0 : seenCnt + 3'd1;
  end

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !evtReady);  // R7
  AST_READY_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    evtReady |-> (32'(fifoFree) >= 5));  // R7
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));  // R6
  AST_HEADER_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtReady) |=> (outValid && outData[7:3] == 5'b10000));  // R2
  AST_TRAILING_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && seenCnt >= 3'd3) |-> (outData == 8'h00));  // R5
endmodule

bind mouse_packet_enc mpe_checker #(.FREE_W(FREE_W)) chk (.*);

// File: tb/mouse_packet_enc_test.sv
`timescale 1ns/100ps
module mouse_packet_enc_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtValid = 1'b0;
  logic evtReady;
  logic [15:0] evtDx = '0, evtDy = '0;
  logic btnLeft = 1'b0, btnMiddle = 1'b0, btnRight = 1'b0;
  logic [3:0] fifoFree = 4'd8;
  logic outValid;
  logic [7:0] outData;
  logic outReady = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [7:0] expQ[$];
  bit busy = 0;
  bit strayEvt = 0;

  always #2.5 clk = ~clk;

  mouse_packet_enc uut (.*);

  function automatic logic [7:0] satByte(int v);
    int c = v;
    if (c > 127) c = 127;
    if (c < -127) c = -127;
    return c[7:0];
  endfunction

  task automatic fail(string tag, int act, int exp);
    miscompares++;
    $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
  endtask

  task automatic step(bit ev, int dx, int dy, bit l, bit m, bit r, int free, bit rdy);
    bit expRdy;
    string tag;
    @(negedge clk);
    evtValid = ev; evtDx = 16'(dx); evtDy = 16'(dy);
    btnLeft = l; btnMiddle = m; btnRight = r;
    fifoFree = 4'(free); outReady = rdy;
    #1;
    vectors++;
    expRdy = !busy && (free >= 5);
    if (evtReady !== expRdy) fail("R7 evtReady", int'(evtReady), int'(expRdy));
    if (outValid !== busy) fail("R6 outValid", int'(outValid), int'(busy));
    if (busy) begin
      case (5 - expQ.size())
        0: tag = "R2 status byte";
        1: tag = "R3 X byte";
        2: tag = "R4 Y byte";
        default: tag = "R5 zero byte";
      endcase
      if (strayEvt) tag = {"R8 ", tag};
      if (outData !== expQ[0]) fail(tag, int'(outData), int'(expQ[0]));
    end
    // model update for the coming edge
    if (busy) begin
      if (ev) strayEvt = 1;
      if (rdy) begin
        void'(expQ.pop_front());
        if (expQ.size() == 0) begin busy = 0; strayEvt = 0; end
      end
    end else if (ev && expRdy) begin
      expQ.push_back(8'h87 & ~{5'b0, l, m, r});
      expQ.push_back(satByte(int'($signed(16'(dx)))));
      expQ.push_back(satByte(-int'($signed(16'(dy)))));
      expQ.push_back(8'h00);
      expQ.push_back(8'h00);
      busy = 1;
    end
  endtask

  // offer one event, then drain its packet with ready always high
  task automatic sendOne(int dx, int dy, bit l, bit m, bit r);
    step(1, dx, dy, l, m, r, 8, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 8, 1);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: idle after reset
    step(0, 0, 0, 0, 0, 0, 8, 0);
    step(0, 0, 0, 0, 0, 0, 3, 0);
    // R2 button patterns
    sendOne(0, 0, 0, 0, 0);
    sendOne(1, -1, 1, 0, 0);
    sendOne(2, -2, 0, 1, 0);
    sendOne(3, -3, 0, 0, 1);
    sendOne(4, 4, 1, 1, 1);
    // R3 / R4 clamp boundaries
    sendOne(127, 127, 0, 0, 0);
    sendOne(128, 128, 0, 0, 0);
    sendOne(-127, -127, 0, 0, 0);
    sendOne(-128, -128, 0, 0, 0);
    sendOne(32767, 32767, 0, 0, 0);
    sendOne(-32768, -32768, 0, 0, 0);
    sendOne(-5, 100, 1, 0, 1);
    // R7 room rule: 4 free blocks, 5 free accepts
    step(1, 9, 9, 0, 0, 0, 4, 1);
    step(1, 9, 9, 0, 0, 0, 4, 1);
    step(1, 10, 11, 0, 1, 0, 5, 1);
    // R8: event held high through the packet, with stalls (R6)
    for (int i = 0; i < 12; i++) step(1, 500, -500, 1, 1, 0, 8, i[0]);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 8, 1);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int dx, dy;
      dx = int'($signed(16'($urandom)));
      dy = int'($signed(16'($urandom)));
      if ($urandom_range(0, 1) == 1) dx = dx % 200;
      if ($urandom_range(0, 1) == 1) dy = dy % 200;
      step($urandom_range(0, 2) != 0, dx, dy, 1'($urandom), 1'($urandom), 1'($urandom),
           $urandom_range(3, 15), $urandom_range(0, 3) != 0);
    end
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 0, 8, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule